// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire I2C bus. It gives a bus master read and write access to a small bank of byte-wide registers. SCL and SDA are synchronised into the local clock domain before use. The block recognises START, repeated START and STOP, and compares the first byte of each transfer with its fixed 7-bit device address. It answers only when that address matches. SDA is driven open-drain: the single output `sda_oe` pulls the line low when high and leaves it released when low.

A single 6-bit register pointer serves both directions, and it keeps its value between transfers. In a write transfer, the first byte after the device address loads the pointer. Every byte after that is stored at the pointer, and the pointer then steps forward. A read transfer returns bytes starting at the pointer, stepping forward after each byte. A master that wants a specific location first performs a write that carries only the sub-address, then issues a repeated START and reads. A read that comes without this setup continues from wherever the last access stopped. The pointer steps from the top register `TOP_ADDR` (0x2D) back to 0x00.

A parallel debug port presents the contents of any register combinationally. There is no data stream at the block edge and therefore no back-pressure: bus bytes move at the pace the master sets on SCL.

Top module: `i2cs_regslave`

## Requirements
- R1: The first byte after a START carries the 7-bit device address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). On a match the slave pulls SDA low for the whole ninth clock.
- R2: On a device address mismatch the slave never drives SDA. It gives no acknowledge, returns all-ones data if clocked, and changes no register until the next START.
- R3: In a write transfer, the low 6 bits of the first data byte load the pointer. Each later byte is stored at the pointer, and the pointer then steps. The slave acknowledges every received byte.
- R4: When the pointer steps from 0x2D, it goes to 0x00, in both reads and writes.
- R5: A read transfer without a preceding sub-address starts at the pointer left by the last access, whether that access was a read or a write. The pointer keeps its value across STOP.
- R6: In a random read, a write transfer that carries only a sub-address is followed by a repeated START and a read address. The read then returns the register at that sub-address, followed by the next registers in sequence.
- R7: While transmitting, the slave sends the next byte when the master acknowledges. After a master NACK it leaves SDA released until the next START or STOP.
- R8: Pointer values 0x2E to 0x3F are reachable only through a loaded sub-address. Reads there return 0x00 and writes there are dropped. The pointer still steps by one, and 0x3F steps to 0x00.
- R9: A STOP or START at any bit position abandons the current byte. A partially received byte is never stored.
- R10: After reset every register holds 0x00, the pointer is 0x00, and SDA is released.
- R11: `dbg_data` shows the register selected by `dbg_addr` without a clock delay, and shows 0x00 for addresses above 0x2D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dbg_addr | input | 6 | Register index for the debug read port |
| dbg_data | output | 8 | Contents of the register at `dbg_addr` |

## Verification
The bench writes a burst that runs past 0x2D. A pointer that failed to wrap would place the last two bytes into nonexistent storage instead of overwriting registers 0x00 and 0x01, and every register is then compared through the debug port. Reads are issued without a sub-address after writes and after other reads. A pointer that was cleared at STOP, or that stepped twice, would return the wrong register. The bench aborts bytes midway with STOP and with repeated START. A design that kept its bit count across these conditions, or stored the partial byte, would then misread the following address byte or corrupt the target register. Foreign-address transfers and clocking after a master NACK check that the slave stays off the bus, since a slave that drove SDA there would flip bits the master reads.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges only count while the clock line stays high
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int              AW       = 6,
  parameter int              DW       = 8,
  parameter logic [AW-1:0]   TOP_ADDR = 6'h2D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int NREG = int'(TOP_ADDR) + 1;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en && wr_addr <= TOP_ADDR) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data  = (rd_addr  <= TOP_ADDR) ? mem[rd_addr]  : '0;
  assign dbg_data = (dbg_addr <= TOP_ADDR) ? mem[dbg_addr] : '0;
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int              AW       = 6,
  parameter int              DW       = 8,
  parameter logic [6:0]      DEV_ADDR = 7'h1A,
  parameter logic [AW-1:0]   TOP_ADDR = 6'h2D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          ptr_step,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe,
  output i2cs_state_e   st
);
  localparam int          CW    = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx;
  logic          rw, first, mack;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == TOP_ADDR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      mack     <= 1'b0;
      ptr      <= '0;
      ptr_step <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      ptr_step <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WBYTE: begin
            if (scl_rise && cnt != LAST) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (st == ST_ADDR) begin
                if (sh[DW-1:1] == DEV_ADDR) begin
                  st     <= ST_AACK;
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                if (first) begin
                  ptr <= sh[AW-1:0];
                end else begin
                  if (ptr <= TOP_ADDR) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= sh;
                  end
                  ptr      <= step_ptr(ptr);
                  ptr_step <= 1'b1;
                end
                st     <= ST_WACK;
                sda_oe <= 1'b1;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              first <= 1'b1;
              if (rw) begin
                st     <= ST_RBYTE;
                tx     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                st     <= ST_WBYTE;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              st     <= ST_WBYTE;
              sda_oe <= 1'b0;
              cnt    <= '0;
              first  <= 1'b0;
            end
          end
          ST_RBYTE: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                st       <= ST_RACK;
                sda_oe   <= 1'b0;
                ptr      <= step_ptr(ptr);
                ptr_step <= 1'b1;
              end else begin
                tx     <= {tx[DW-2:0], 1'b0};
                sda_oe <= ~tx[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= ST_RBYTE;
                cnt    <= '0;
                tx     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regslave.sv
module i2cs_regslave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1A,
  parameter int         AW          = 6,
  parameter int         DW          = 8,
  parameter logic [5:0] TOP_ADDR    = 6'h2D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] rd_data, wr_data;
  logic [AW-1:0] ptr, wr_addr;
  logic          ptr_step, wr_en;
  i2cs_state_e   st;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2cs_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR), .TOP_ADDR(AW'(TOP_ADDR))) u_fsm (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_data, .ptr, .ptr_step, .wr_en, .wr_addr, .wr_data, .sda_oe, .st
  );

  i2cs_regbank #(.AW(AW), .DW(DW), .TOP_ADDR(AW'(TOP_ADDR))) u_bank (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .rd_addr(ptr), .rd_data, .dbg_addr, .dbg_data
  );
endmodule

// File: rtl/i2cs_regslave_chk.sv
module i2cs_regslave_chk
  import i2cs_pkg::*;
#(
  parameter int         AW       = 6,
  parameter logic [5:0] TOP_ADDR = 6'h2D
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_det,
  input i2cs_state_e   st,
  input logic          sda_oe,
  input logic [AW-1:0] ptr,
  input logic          ptr_step,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  // R1: own address or received byte is acknowledged during the ninth clock
  a_r1_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK || st == ST_WACK) |-> sda_oe);

  // R2: nothing is driven while not engaged in a transfer
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R4: an automatic step goes from the top register to zero, else by one
  a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |-> (($past(ptr) == AW'(TOP_ADDR)) ? (ptr == '0)
                                                : (ptr == AW'($past(ptr) + 1'b1))));

  // R7: the master's acknowledge slot is left free
  a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK) |-> !sda_oe);

  // R8: writes never reach an index above the top register
  a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= AW'(TOP_ADDR)));

  // R9: STOP returns the bit engine to idle with SDA released
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe));
endmodule

bind i2cs_regslave i2cs_regslave_chk #(.AW(AW), .TOP_ADDR(TOP_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .st(st), .sda_oe(sda_oe),
  .ptr(ptr), .ptr_step(ptr_step), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_i2cs_regslave.sv
module sim_i2cs_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int TOP        = 45;
  localparam logic [7:0] WADDR = 8'h34;
  localparam logic [7:0] RADDR = 8'h35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [5:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic sda_line;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [64];
  int mptr = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2cs_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == TOP) ? 0 : ((p + 1) & 63);
  endfunction

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b;     qwait();
    scl_m = 1'b1;  qwait();
    s = sda_line;  qwait();
    scl_m = 1'b0;  qwait();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(~mack, s);
  endtask

  task automatic read_seq(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(req, d, model[mptr]);
      mptr = nxt(mptr);
    end
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    @(negedge clk);
    dbg_addr = 6'(a);
    #1;
    v = dbg_data;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic s;
    logic [7:0] v;
    logic [7:0] d;
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: SDA released and all registers clear after reset; R11 and R8 via debug port
    chk("R10 sda_oe after reset", sda_oe, 0);
    for (int a = 0; a < 64; a++) begin
      peek(a, v);
      chk("R10/R11 reset contents", v, 0);
    end

    // R1, R3, R4: burst of 48 writes starting at 0, running past the top register
    bus_start();
    send_byte(WADDR, ack);
    chk("R1 write address ack", ack, 1);
    send_byte(8'h00, ack);
    chk("R3 sub-address ack", ack, 1);
    mptr = 0;
    for (int i = 0; i < 48; i++) begin
      v = 8'((i * 29 + 7) ^ (i >> 2));
      send_byte(v, ack);
      chk("R3 data ack", ack, 1);
      if (mptr <= TOP) model[mptr] = v;
      mptr = nxt(mptr);
    end
    bus_stop();
    for (int a = 0; a < 64; a++) begin
      peek(a, v);
      chk("R3/R4/R11 contents after wrapping burst", v, model[a]);
    end

    // R5, R7: read without sub-address continues from the write pointer (now 2)
    bus_start();
    send_byte(RADDR, ack);
    chk("R1 read address ack", ack, 1);
    read_seq(3, "R5/R7 current-address burst");
    // R7: after NACK the slave stays off the bus
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    chk("R7 released after NACK", d, 8'hFF);
    bus_stop();

    // R5: pointer persists across STOP after a read
    bus_start();
    send_byte(RADDR, ack);
    read_seq(1, "R5 persisted pointer");
    bus_stop();

    // R6, R4: random read across the top register
    bus_start();
    send_byte(WADDR, ack);
    send_byte(8'h2C, ack);
    mptr = 8'h2C;
    bus_start();
    send_byte(RADDR, ack);
    chk("R6 read address after repeated START", ack, 1);
    read_seq(4, "R6/R4 random read wrap");
    bus_stop();

    // R2: foreign address, write attempt
    peek(5, v);
    bus_start();
    send_byte(WADDR ^ 8'h02, ack);
    chk("R2 no ack foreign write", ack, 0);
    send_byte(8'h05, ack);
    chk("R2 no ack sub-address", ack, 0);
    send_byte(8'hAA, ack);
    bus_stop();
    peek(5, d);
    chk("R2 register untouched", d, v);
    // R2: foreign address, read attempt returns all-ones
    bus_start();
    send_byte(RADDR ^ 8'h02, ack);
    chk("R2 no ack foreign read", ack, 0);
    recv_byte(1'b0, d);
    chk("R2 released during foreign read", d, 8'hFF);
    bus_stop();

    // R8: writes above the top register are dropped
    bus_start();
    send_byte(WADDR, ack);
    send_byte(8'h30, ack);
    send_byte(8'h55, ack);
    chk("R8 ack above top", ack, 1);
    send_byte(8'h56, ack);
    bus_stop();
    peek(8'h30, v);
    chk("R8 dropped write 0x30", v, 0);
    peek(8'h31, v);
    chk("R8 dropped write 0x31", v, 0);
    // R8: read from 0x3E steps through 0x3F to 0x00
    bus_start();
    send_byte(WADDR, ack);
    send_byte(8'h3E, ack);
    mptr = 8'h3E;
    bus_start();
    send_byte(RADDR, ack);
    read_seq(3, "R8 read above top and step to zero");
    bus_stop();

    // R9: STOP in mid-byte stores nothing
    bus_start();
    send_byte(WADDR, ack);
    send_byte(8'h10, ack);
    mptr = 8'h10;
    bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s); bit_io(1'b0, s);
    bus_stop();
    peek(8'h10, v);
    chk("R9 partial byte not stored", v, model[8'h10]);
    bus_start();
    send_byte(RADDR, ack);
    chk("R9 clean address after mid-byte STOP", ack, 1);
    read_seq(1, "R9 pointer after mid-byte STOP");
    bus_stop();

    // R9: repeated START in mid-byte restarts address reception
    bus_start();
    send_byte(WADDR, ack);
    send_byte(8'h21, ack);
    mptr = 8'h21;
    bit_io(1'b1, s); bit_io(1'b1, s); bit_io(1'b1, s);
    bus_start();
    send_byte(RADDR, ack);
    chk("R9 address after mid-byte START", ack, 1);
    read_seq(2, "R9 read after mid-byte START");
    bus_stop();
    peek(8'h21, v);
    chk("R9 target unchanged", v, model[8'h21]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule